// File: doc/BRIEF.md
# Status Byte and Service Request Block

This block collects summary flags from several status sources into an 8-bit status byte. When any enabled summary flag is active, it raises a service request line toward the host. Six of the status-byte bits copy external summary levels. Bit 5 is the summary of a local latched event register. Bit 6 is the master summary. It is the OR of the other seven bits, each ANDed with the matching bit of a writable 8-bit service request enable register.

The event register collects single-cycle event pulses. Each bit stays set until software reads the register, and the read clears it. A separate event enable mask selects which event bits feed the bit-5 summary. Software reaches all four registers through a simple register port. It has a write strobe and a read strobe, a 2-bit address and 8-bit data. Read data is combinational in the same cycle as the strobe.

Address map:
- 0: status byte (read only)
- 1: service request enable
- 2: event register (cleared by a read)
- 3: event enable

Top module: `svc_req_top`

## Requirements
- R1: After reset, the service request enable register, the event register and the event enable register read 0, and `srqOut` is 0.
- R2: A write to address 1 loads the service request enable register. Reading address 1 returns the written value with bit 6 forced to 0.
- R3: Writing 0 to address 1 clears the enable register, and `srqOut` then falls.
- R4: Status-byte bits 0–4 follow `extSummary[4:0]`, and bit 7 follows `extSummary[5]`. These bits do not latch and track the input level in the same cycle.
- R5: Status-byte bit 6 is 1 exactly when some status-byte bit in positions 0–5 or 7 is 1 and the matching enable bit is also 1. Enable bit 6 has no effect.
- R6: `srqOut` equals status-byte bit 6 as it was one clock cycle earlier.
- R7: A 1 on bit i of `evtPulse` for one cycle sets event bit i. The bit stays set across later cycles until the event register is read.
- R8: Reading address 2 returns the current event bits and clears the event register at that clock edge.
- R9: If an event pulse arrives in the same cycle as a read of address 2, the read returns the old value and the new pulse bit is set afterwards.
- R10: Status-byte bit 5 is 1 exactly when the event register ANDed with the event enable register is nonzero. The bit drops to 0 after a read that clears the event register.
- R11: A write to address 0 changes no register. Reads of addresses 0, 1 and 3 do not clear the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of address 2 clears the events) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| extSummary | input | 6 | External summary levels for status bits 0–4 and 7 |
| evtPulse | input | 8 | Single-cycle event pulses |
| srqOut | output | 1 | Service request level |

## Verification
The assertions assume that the write strobe and the read strobe are never high in the same cycle. The control asserts this. The stimulus tasks drive only one access per cycle, and they drive inputs on the falling edge, so every input is stable at the rising edge. The pulse-sets-bit property assumes that `evtPulse` carries whole pulses. The bench drives each pulse for exactly one cycle, with one deliberate case where the pulse lands on the same edge as a clearing read.

// File: rtl/svc_req_pkg.sv
package svc_req_pkg;
  localparam int STB_W  = 8;
  localparam int EVT_W  = 8;
  localparam int ADDR_W = 2;
  localparam int EXT_W  = STB_W - 2;
  localparam int ESB_POS = 5;
  localparam int MSS_POS = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_SRE    = 2'd1,
    ADDR_EVT    = 2'd2,
    ADDR_EVTEN  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic sreWr;
    logic evtEnWr;
    logic evtClr;
  } regStrobe_t;
endpackage

// File: rtl/svc_req_ctrl.sv
module svc_req_ctrl
  import svc_req_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);
  regAddr_e addrDec;

  always_comb begin
    addrDec = regAddr_e'(addr);
    strb = '0;
    if (wrEn) begin
      case (addrDec)
        ADDR_SRE:   strb.sreWr   = 1'b1;
        ADDR_EVTEN: strb.evtEnWr = 1'b1;
        default:    ;
      endcase
    end
    if (rdEn && addrDec == ADDR_EVT) strb.evtClr = 1'b1;
  end

  // Only one register access is allowed per cycle.
  assert_single_access_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sreWr, strb.evtEnWr, strb.evtClr}));
endmodule

// File: rtl/svc_req_dp.sv
module svc_req_dp
  import svc_req_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STB_W-1:0]  wrData,
  input  logic [EXT_W-1:0]  extSummary,
  input  logic [EVT_W-1:0]  evtPulse,
  output logic [STB_W-1:0]  rdData,
  output logic              srqOut
);
  localparam logic [STB_W-1:0] MSS_MASK = STB_W'(1) << MSS_POS;

  logic [STB_W-1:0] sreReg;
  logic [EVT_W-1:0] evtReg;
  logic [EVT_W-1:0] evtEnReg;
  logic [STB_W-1:0] summaryBits;
  logic [STB_W-1:0] statusByte;
  logic             esbBit;
  logic             mssBit;
  logic             srqReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sreReg   <= '0;
      evtEnReg <= '0;
    end else begin
      if (strb.sreWr)   sreReg   <= wrData & ~MSS_MASK;
      if (strb.evtEnWr) evtEnReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtReg <= '0;
    else       evtReg <= (strb.evtClr ? '0 : evtReg) | evtPulse;
  end

  assign esbBit = |(evtReg & evtEnReg);

  always_comb begin
    summaryBits = '0;
    summaryBits[ESB_POS-1:0] = extSummary[ESB_POS-1:0];
    summaryBits[ESB_POS]     = esbBit;
    summaryBits[STB_W-1]     = extSummary[EXT_W-1];
  end

  assign mssBit     = |(summaryBits & sreReg & ~MSS_MASK);
  assign statusByte = summaryBits | (mssBit ? MSS_MASK : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srqReg <= 1'b0;
    else       srqReg <= mssBit;
  end
  assign srqOut = srqReg;

  always_comb begin
    case (regAddr_e'(addr))
      ADDR_STATUS: rdData = statusByte;
      ADDR_SRE:    rdData = sreReg;
      ADDR_EVT:    rdData = evtReg;
      default:     rdData = evtEnReg;
    endcase
  end

  assert_mss_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[MSS_POS] |-> (sreReg != '0));

  assert_srq_quiet_no_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sreReg == '0) |=> !srqOut);

  assert_pulse_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((evtReg & $past(evtPulse)) == $past(evtPulse)));

  assert_sticky_events_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.evtClr |=> ((evtReg & $past(evtReg)) == $past(evtReg)));

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.evtClr |=> ((evtReg & ~$past(evtPulse)) == '0));

  assert_esb_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtClr && evtPulse == '0) |=> !statusByte[ESB_POS]);
endmodule

// File: rtl/svc_req_top.sv
module svc_req_top
  import svc_req_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STB_W-1:0]  regWrData,
  output logic [STB_W-1:0]  regRdData,
  input  logic [EXT_W-1:0]  extSummary,
  input  logic [EVT_W-1:0]  evtPulse,
  output logic              srqOut
);
  regStrobe_t strb;

  svc_req_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (regWrEn),
    .rdEn  (regRdEn),
    .addr  (regAddr),
    .strb  (strb)
  );

  svc_req_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (regAddr),
    .wrData     (regWrData),
    .extSummary (extSummary),
    .evtPulse   (evtPulse),
    .rdData     (regRdData),
    .srqOut     (srqOut)
  );
endmodule

// File: tb/svc_req_top_bench.sv
module svc_req_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [5:0] extSummary = '0;
  logic [7:0] evtPulse = '0;
  logic       srqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  svc_req_top u_svc_req_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extSummary(extSummary), .evtPulse(evtPulse), .srqOut(srqOut)
  );

  // {extSummary, enable written, expected status byte}, event register empty
  localparam logic [21:0] VEC [8] = '{
    {6'h01, 8'h01, 8'h41},
    {6'h01, 8'h02, 8'h01},
    {6'h20, 8'h80, 8'hC0},
    {6'h1F, 8'h00, 8'h1F},
    {6'h10, 8'h50, 8'h50},
    {6'h00, 8'h40, 8'h00},
    {6'h3F, 8'hFF, 8'hDF},
    {6'h0A, 8'h04, 8'h0A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk);
    evtPulse = p;
    @(negedge clk);
    evtPulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead(2'd1, rd); check("R1 enable", rd, 8'h00);
    regRead(2'd2, rd); check("R1 event", rd, 8'h00);
    regRead(2'd3, rd); check("R1 event enable", rd, 8'h00);
    check("R1 srq", {7'd0, srqOut}, 8'h00);

    // Table: R2, R4, R5, R6
    for (int i = 0; i < 8; i++) begin
      logic [5:0] ext;
      logic [7:0] sre;
      logic [7:0] exp;
      {ext, sre, exp} = VEC[i];
      regWrite(2'd1, sre);
      extSummary = ext;
      @(negedge clk);
      regRead(2'd0, rd); check("R4/R5 status", rd, exp);
      check("R6 srq", {7'd0, srqOut}, {7'd0, exp[6]});
      regRead(2'd1, rd); check("R2 enable readback", rd, sre & 8'hBF);
    end

    // R4 non-latching: drop input, bits drop same cycle
    regWrite(2'd1, 8'h01);
    extSummary = 6'h01;
    @(negedge clk);
    check("R6 srq high", {7'd0, srqOut}, 8'h01);
    extSummary = 6'h00;
    #1 regAddr = 2'd0;
    #1 check("R4 no latch", regRdData, 8'h00);
    @(negedge clk);
    check("R6 srq follows one cycle", {7'd0, srqOut}, 8'h00);

    // R3 writing zero clears enable
    extSummary = 6'h01;
    @(negedge clk);
    check("R3 srq before clear", {7'd0, srqOut}, 8'h01);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R3 enable cleared", rd, 8'h00);
    check("R3 srq low", {7'd0, srqOut}, 8'h00);
    extSummary = 6'h00;

    // R7, R10 events
    regWrite(2'd3, 8'h05);
    regRead(2'd3, rd); check("R10 event enable readback", rd, 8'h05);
    pulse(8'h02);
    repeat (3) @(negedge clk);
    regRead(2'd0, rd); check("R10 masked event no esb", rd, 8'h00);
    pulse(8'h04);
    repeat (3) @(negedge clk);
    regWrite(2'd1, 8'h20);
    @(negedge clk);
    regRead(2'd0, rd); check("R10 esb and mss", rd, 8'h60);
    check("R6 srq from esb", {7'd0, srqOut}, 8'h01);

    // R11 ignored accesses
    regWrite(2'd0, 8'hFF);
    regRead(2'd1, rd); check("R11 enable untouched", rd, 8'h20);
    regRead(2'd3, rd); check("R11 event enable untouched", rd, 8'h05);
    regRead(2'd0, rd); check("R11 status read keeps events", rd, 8'h60);

    // R8 clear on read
    regRead(2'd2, rd); check("R8 read value", rd, 8'h06);
    regRead(2'd2, rd); check("R8 cleared", rd, 8'h00);
    regRead(2'd0, rd); check("R10 esb dropped", rd, 8'h00);

    // R9 pulse during read
    pulse(8'h01);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'd2; evtPulse = 8'h10;
    #1 rd = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; evtPulse = 8'h00;
    check("R9 read returns old", rd, 8'h01);
    regRead(2'd2, rd); check("R9 new bit kept", rd, 8'h10);

    // R1 reset mid-run
    regWrite(2'd1, 8'hFF);
    pulse(8'hFF);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    regRead(2'd1, rd); check("R1 enable after reset", rd, 8'h00);
    regRead(2'd2, rd); check("R1 event after reset", rd, 8'h00);
    check("R1 srq after reset", {7'd0, srqOut}, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule